// File: doc/BRIEF.md
# Buck Regulator Fault Latch and Power-Good Supervisor

This block is the digital supervisor that sits beside the analog core of a buck regulator controller. It receives comparator flags that change at any time, brings them into the clock domain, and from them decides three things. It decides whether the output may be reported healthy. It decides whether a sustained under-voltage has to shut the converter down. It decides how the output capacitors are drained once that has happened.

A time filter guards the under-voltage flag, and the filter is blanked during the early part of soft-start. When the filter trips, a sticky fault flag is set. That flag blocks the high-side gate and gives the low-side gate to a two-state discharge loop. The loop pulls the output down to a lower threshold, releases it until it recovers past an upper threshold, and repeats, so the output never swings negative. A separate load switch bleeds the output whenever the fault is set or the converter is disabled. Only a power-on reset or an enable that goes low and then high again releases the fault.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: `powerGood` is 1 only when the S3 state input, the soft-start-above-4V flag, the feedback-in-window flag and the auxiliary-regulators-good flag are all 1 and no fault is latched. Otherwise it is 0.
- R2: The fault is latched when the synchronized under-voltage flag stays 1 for `UV_LIMIT` consecutive clocks. A run of `UV_LIMIT`-1 clocks does not latch it, and any clock with the flag at 0 restarts the count.
- R3: While the soft-start-above-1.3V flag is 0, the under-voltage flag cannot latch the fault and the filter count stays at zero.
- R4: While the fault is latched, `loGate` is 1 until the output-below-0.5V flag is seen. It then stays 0 until the output-above-0.8V flag is seen, and this repeats. The first state after latching is the pull-down (1) state.
- R5: `dischLoad` is 1 whenever the fault is latched or the synchronized enable is 0, and 0 otherwise.
- R6: Once latched, the fault clears only on reset or on a synchronized low-to-high edge of enable after at least one clock low. Clearing the under-voltage condition or holding enable high has no effect.
- R7: While the fault is latched, `hiGate` is 0. With no fault latched, `hiGate` follows `pwmHighIn` and `loGate` follows `pwmLowIn`.
- R8: Every comparator input passes through a two-flop synchronizer, so a change reaches the outputs no sooner than two rising edges later.
- R9: During and straight after reset, the fault is clear, `powerGood` is 0 and `dischLoad` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Active-low power-on reset |
| uvFlagIn | input | 1 | Feedback below under-voltage threshold (async) |
| fbInWinIn | input | 1 | Feedback within regulation window (async) |
| ss4In | input | 1 | Soft-start above 4V (async) |
| ss13In | input | 1 | Soft-start above 1.3V (async) |
| outBelowLoIn | input | 1 | Output below 0.5V (async) |
| outAboveHiIn | input | 1 | Output above 0.8V (async) |
| auxGoodIn | input | 1 | Auxiliary regulators in regulation (async) |
| s3In | input | 1 | S3 power-state input (async) |
| enIn | input | 1 | Converter enable (async) |
| pwmHighIn | input | 1 | High-side gate request from PWM logic |
| pwmLowIn | input | 1 | Low-side gate request from PWM logic |
| powerGood | output | 1 | Power-good indication |
| hiGate | output | 1 | High-side gate command |
| loGate | output | 1 | Low-side gate command |
| dischLoad | output | 1 | Output discharge load switch enable |

## Verification
The bench builds the block with `UV_LIMIT` set to 8 rather than the 2 µs default of 200. The pulse that stops one clock short of the limit and the pulse that reaches it are then short directed runs, and the blanking run can hold the flag for twice the limit without a long simulation. With that small limit, a whole fault episode fits in a compact directed sequence: latch, several discharge toggles at both thresholds, and release by an enable toggle.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  localparam int IDX_UV    = 0;
  localparam int IDX_FBWIN = 1;
  localparam int IDX_SS4   = 2;
  localparam int IDX_SS13  = 3;
  localparam int IDX_LOW   = 4;
  localparam int IDX_HIGH  = 5;
  localparam int IDX_AUX   = 6;
  localparam int IDX_S3    = 7;
  localparam int IDX_EN    = 8;
  localparam int NUM_FLAGS = 9;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    DIS_IDLE = 2'd0,
    DIS_PULL = 2'd1,
    DIS_WAIT = 2'd2
  } dischState_t;

  typedef struct packed {
    logic faultOn;
    logic lowPull;
    logic loadOn;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwr_sup_sync.sv
module pwr_sup_sync
  import pwr_sup_pkg::*;
#(
  parameter int WIDTH = NUM_FLAGS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [SYNC_DEPTH-1:0] stages;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stages <= '0;
      else       stages <= {stages[SYNC_DEPTH-2:0], rawIn[g]};
    end
    assign syncOut[g] = stages[SYNC_DEPTH-1];
  end
endmodule

// File: rtl/pwr_sup_ctrl.sv
module pwr_sup_ctrl
  import pwr_sup_pkg::*;
#(
  parameter int UV_LIMIT = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sUv,
  input  logic        sSs13,
  input  logic        sBelowLo,
  input  logic        sAboveHi,
  input  logic        sEn,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = $clog2(UV_LIMIT + 1);
  localparam logic [CNT_W-1:0] TRIP_AT = CNT_W'(UV_LIMIT - 1);

  logic [CNT_W-1:0] uvCnt;
  logic             faultQ;
  logic             enPrev;
  dischState_t      dState;
  logic             uvArmed;
  logic             uvTrip;
  logic             enRise;

  assign uvArmed = sUv && sSs13;
  assign uvTrip  = uvArmed && (uvCnt == TRIP_AT);
  assign enRise  = sEn && !enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     uvCnt <= '0;
    else if (!uvArmed)             uvCnt <= '0;
    else if (uvCnt != TRIP_AT + 1'b1) uvCnt <= uvCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      enPrev <= sEn;
      if (enRise)      faultQ <= 1'b0;
      else if (uvTrip) faultQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dState <= DIS_IDLE;
    else if (enRise) dState <= DIS_IDLE;
    else begin
      unique case (dState)
        DIS_IDLE: if (uvTrip)   dState <= DIS_PULL;
        DIS_PULL: if (sBelowLo) dState <= DIS_WAIT;
        DIS_WAIT: if (sAboveHi) dState <= DIS_PULL;
        default:                dState <= DIS_IDLE;
      endcase
    end
  end

  assign strobe.faultOn = faultQ;
  assign strobe.lowPull = (dState == DIS_PULL);
  assign strobe.loadOn  = faultQ || !sEn;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    uvCnt <= CNT_W'(UV_LIMIT)); // R2
  AST_TRIP_NEEDS_UV: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultQ) |-> $past(sUv)); // R2
  AST_TRIP_NEEDS_SS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultQ) |-> $past(sSs13)); // R3
  AST_BLANK_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(!sSs13) |-> uvCnt == '0); // R3
  AST_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultQ) |-> ($past(sEn) && !$past(sEn, 2))); // R6
  AST_RELOAD_NEEDS_HI: assert property (@(posedge clk) disable iff (!rstN)
    (dState == DIS_PULL && $past(dState) == DIS_WAIT) |-> $past(sAboveHi)); // R4
  AST_RELEASE_NEEDS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (dState == DIS_WAIT && $past(dState) == DIS_PULL) |-> $past(sBelowLo)); // R4
endmodule

// File: rtl/pwr_sup_datapath.sv
module pwr_sup_datapath
  import pwr_sup_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] sFlags,
  input  ctrlStrobe_t          strobe,
  input  logic                 pwmHighIn,
  input  logic                 pwmLowIn,
  output logic                 powerGood,
  output logic                 hiGate,
  output logic                 loGate,
  output logic                 dischLoad
);
  always_comb begin
    powerGood = sFlags[IDX_S3] && sFlags[IDX_SS4] && sFlags[IDX_FBWIN]
                && sFlags[IDX_AUX] && !strobe.faultOn;
    hiGate    = strobe.faultOn ? 1'b0 : pwmHighIn;
    loGate    = strobe.faultOn ? strobe.lowPull : pwmLowIn;
    dischLoad = strobe.loadOn;
  end

  AST_PG_BLOCKED_BY_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.faultOn) |-> !powerGood); // R1
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int UV_LIMIT = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic uvFlagIn,
  input  logic fbInWinIn,
  input  logic ss4In,
  input  logic ss13In,
  input  logic outBelowLoIn,
  input  logic outAboveHiIn,
  input  logic auxGoodIn,
  input  logic s3In,
  input  logic enIn,
  input  logic pwmHighIn,
  input  logic pwmLowIn,
  output logic powerGood,
  output logic hiGate,
  output logic loGate,
  output logic dischLoad
);
  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] sFlags;
  ctrlStrobe_t          strobe;

  always_comb begin
    rawFlags           = '0;
    rawFlags[IDX_UV]    = uvFlagIn;
    rawFlags[IDX_FBWIN] = fbInWinIn;
    rawFlags[IDX_SS4]   = ss4In;
    rawFlags[IDX_SS13]  = ss13In;
    rawFlags[IDX_LOW]   = outBelowLoIn;
    rawFlags[IDX_HIGH]  = outAboveHiIn;
    rawFlags[IDX_AUX]   = auxGoodIn;
    rawFlags[IDX_S3]    = s3In;
    rawFlags[IDX_EN]    = enIn;
  end

  pwr_sup_sync #(.WIDTH(NUM_FLAGS)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(rawFlags), .syncOut(sFlags)
  );

  pwr_sup_ctrl #(.UV_LIMIT(UV_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sUv(sFlags[IDX_UV]), .sSs13(sFlags[IDX_SS13]),
    .sBelowLo(sFlags[IDX_LOW]), .sAboveHi(sFlags[IDX_HIGH]),
    .sEn(sFlags[IDX_EN]), .strobe(strobe)
  );

  pwr_sup_datapath u_dp (
    .clk(clk), .rstN(rstN), .sFlags(sFlags), .strobe(strobe),
    .pwmHighIn(pwmHighIn), .pwmLowIn(pwmLowIn),
    .powerGood(powerGood), .hiGate(hiGate), .loGate(loGate),
    .dischLoad(dischLoad)
  );

  AST_PG_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> ($past(fbInWinIn, 2) && $past(s3In, 2))); // R8
  AST_HI_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.faultOn |-> !hiGate); // R7
  AST_LOAD_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.faultOn |-> dischLoad); // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |-> (!powerGood && dischLoad)); // R9
endmodule

// File: tb/pwr_fault_supervisor_bench.sv
module pwr_fault_supervisor_bench;
  localparam int LIM = 8;
  localparam int NPG = 8;
  // {s3, ss4, fbWin, aux, expected powerGood}
  localparam logic [4:0] PG_TABLE [NPG] = '{
    5'b1111_1, 5'b0111_0, 5'b1011_0, 5'b1101_0,
    5'b1110_0, 5'b0000_0, 5'b1001_0, 5'b1111_1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uvFlagIn = 0, fbInWinIn = 0, ss4In = 0, ss13In = 0;
  logic outBelowLoIn = 0, outAboveHiIn = 0, auxGoodIn = 0, s3In = 0;
  logic enIn = 0, pwmHighIn = 0, pwmLowIn = 0;
  logic powerGood, hiGate, loGate, dischLoad;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_fault_supervisor #(.UV_LIMIT(LIM)) u_pwr_fault_supervisor (
    .clk(clk), .rstN(rstN), .uvFlagIn(uvFlagIn), .fbInWinIn(fbInWinIn),
    .ss4In(ss4In), .ss13In(ss13In), .outBelowLoIn(outBelowLoIn),
    .outAboveHiIn(outAboveHiIn), .auxGoodIn(auxGoodIn), .s3In(s3In),
    .enIn(enIn), .pwmHighIn(pwmHighIn), .pwmLowIn(pwmLowIn),
    .powerGood(powerGood), .hiGate(hiGate), .loGate(loGate),
    .dischLoad(dischLoad)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic uvPulse(input int n);
    @(negedge clk);
    uvFlagIn = 1'b1;
    repeat (n) @(negedge clk);
    uvFlagIn = 1'b0;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(powerGood, 1'b0, "R9 pg in reset");
    chk(dischLoad, 1'b1, "R9 load in reset");
    rstN = 1'b1;
    enIn = 1'b1; ss13In = 1'b1;
    settle();
    chk(dischLoad, 1'b0, "R5 load off when enabled, no fault");

    for (int i = 0; i < NPG; i++) begin
      {s3In, ss4In, fbInWinIn, auxGoodIn} = PG_TABLE[i][4:1];
      settle();
      chk(powerGood, PG_TABLE[i][0], $sformatf("R1 table row %0d", i));
    end

    // R8: change is not visible after only one edge
    @(negedge clk); fbInWinIn = 1'b0;
    @(negedge clk);
    chk(powerGood, 1'b1, "R8 one edge after change");
    @(negedge clk);
    chk(powerGood, 1'b0, "R8 two edges after change");
    fbInWinIn = 1'b1; settle();

    pwmHighIn = 1'b1; pwmLowIn = 1'b0; settle();
    chk(hiGate, 1'b1, "R7 hiGate follows pwm");
    chk(loGate, 1'b0, "R7 loGate follows pwm");

    // R3: blanking during soft-start
    ss13In = 1'b0; settle();
    uvPulse(2 * LIM);
    chk(dischLoad, 1'b0, "R3 blanked uv no fault");
    chk(powerGood, 1'b1, "R3 pg kept while blanked");
    ss13In = 1'b1; settle();

    // R2: one short of the limit, then broken runs
    uvPulse(LIM - 1);
    chk(dischLoad, 1'b0, "R2 limit-1 no latch");
    uvPulse(LIM - 1);
    chk(dischLoad, 1'b0, "R2 count restarts after gap");
    uvPulse(LIM);
    chk(dischLoad, 1'b1, "R2 limit latches");
    chk(powerGood, 1'b0, "R1 pg low on fault");
    chk(hiGate, 1'b0, "R7 hiGate forced off");

    // R4: discharge loop
    chk(loGate, 1'b1, "R4 first pull");
    outBelowLoIn = 1'b1; settle();
    chk(loGate, 1'b0, "R4 release below 0.5");
    outBelowLoIn = 1'b0; settle();
    chk(loGate, 1'b0, "R4 stays low between thresholds");
    outAboveHiIn = 1'b1; settle();
    chk(loGate, 1'b1, "R4 repull above 0.8");
    outAboveHiIn = 1'b0; settle();
    chk(loGate, 1'b1, "R4 stays high between thresholds");
    chk(dischLoad, 1'b1, "R6 fault held with enable high");

    // R6: enable toggle clears
    enIn = 1'b0; settle();
    chk(dischLoad, 1'b1, "R5 load on while disabled");
    chk(hiGate, 1'b0, "R6 fault kept while enable low");
    enIn = 1'b1; settle();
    chk(dischLoad, 1'b0, "R6 cleared by enable edge");
    chk(hiGate, 1'b1, "R7 hiGate restored");
    chk(powerGood, 1'b1, "R1 pg restored");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule